// File: doc/BRIEF.md
# Display RAM Window Write Address Generator

This block sits between the command decoder of a grey-scale OLED controller and its 5120-byte frame memory. Each incoming data byte holds two 4-bit pixels. The block turns every byte strobe into one memory write. The address comes from a column counter (0..63) and a row counter (0..79), and the byte address is `column + row*64`.

The command decoder can load a rectangular window for columns and rows, plus a traversal-mode byte. After each write the counters step through the window. In horizontal traversal the column advances first. In vertical traversal the row advances first. Both counters wrap back to their window start, so a host can stream a sub-rectangle of the frame without sending any address between bytes.

Every write also raises a redraw flag. The flag stays set until the scan-out side clears it.

Top module: `awc_addr_gen`

## Requirements
- R1: Each `data_valid` strobe produces exactly one memory write. The write carries `data_in` unchanged at byte address `col + row*64`, which always lies in 0..5119.
- R2: In horizontal traversal the column counter advances by one after each write. When a write happens at the column end, the column reloads the column start and the row counter steps.
- R3: In horizontal traversal, when the row steps while at the row end, the row reloads the row start.
- R4: Traversal is vertical when bit 2 (mask 0x04) of the loaded mode byte is 1, and horizontal when it is 0. All other bits of that byte have no effect. In vertical traversal the row advances first. At the row end the row reloads its start and the column steps. At the column end the column reloads its start.
- R5: A column window load reduces its start and end values modulo 64 and moves the current column to the reduced start.
- R6: A row window load reduces its start and end values modulo 80 and moves the current row to the reduced start.
- R7: After reset the window spans columns 0..63 and rows 0..79, traversal is horizontal, both counters are 0, `mem_we` is 0 and `redraw` is 0.
- R8: A write sets `redraw` on the edge that captures the strobe. `redraw_clr` clears it. If a strobe and a clear arrive in the same cycle, the set wins. Otherwise the flag holds its value.
- R9: If a window load or mode load arrives in the same cycle as a strobe, the load applies first. The write then uses the new start address and the new mode.
- R10: If an end value is below its start value, the next step from the start wraps straight back to the start.
- R11: `mem_we`, `mem_addr` and `mem_data` are registered and appear in the cycle right after the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_win_load | input | 1 | Strobe: load column window |
| col_start_in | input | 8 | Column window start (reduced modulo 64) |
| col_end_in | input | 8 | Column window end (reduced modulo 64) |
| row_win_load | input | 1 | Strobe: load row window |
| row_start_in | input | 8 | Row window start (reduced modulo 80) |
| row_end_in | input | 8 | Row window end (reduced modulo 80) |
| mode_load | input | 1 | Strobe: load traversal mode byte |
| mode_in | input | 8 | Mode byte; bit 2 selects vertical traversal |
| data_valid | input | 1 | Strobe: one pixel byte is present |
| data_in | input | 8 | Pixel byte (two 4-bit pixels) |
| redraw_clr | input | 1 | Scan-out side clears the redraw flag |
| mem_we | output | 1 | Frame memory write enable |
| mem_addr | output | 13 | Frame memory byte address |
| mem_data | output | 8 | Frame memory write data |
| redraw | output | 1 | Frame content changed since the last clear |

## Verification
Every result of the block is due one clock edge after its stimulus. The write beat and the redraw flag both come from the edge that captures the strobe, and a clear also acts on the edge that captures it. A window or mode load has no visible output of its own. Its effect shows up in the address of the next write, or of the same-cycle write for R9.

The bench drives every input at the falling edge. It holds a strobe for exactly one rising edge, then samples all outputs at the following falling edge, so each check lands half a cycle after the edge that should produce the result. The expected addresses are fixed sequences worked out by hand from the window rules, including wrap, modulo reduction and inverted windows.

// File: rtl/awc_pkg.sv
`timescale 1ns/1ps
package awc_pkg;

    localparam int FB_COLS   = 64;
    localparam int FB_ROWS   = 80;
    localparam int BYTE_W    = 8;
    localparam int COL_W     = $clog2(FB_COLS);
    localparam int ROW_W     = $clog2(FB_ROWS);
    localparam int FB_BYTES  = FB_COLS * FB_ROWS;
    localparam int FB_ADDR_W = $clog2(FB_BYTES);

    typedef enum logic {
        TRAV_HORIZ = 1'b0,
        TRAV_VERT  = 1'b1
    } trav_e;

    typedef struct packed {
        logic                 we;
        logic [FB_ADDR_W-1:0] addr;
        logic [BYTE_W-1:0]    data;
    } wr_beat_t;

    // Reduce an 8-bit command value modulo m by repeated subtraction.
    function automatic logic [BYTE_W-1:0] mod_reduce(input logic [BYTE_W-1:0] v,
                                                     input int m);
        logic [BYTE_W-1:0] r;
        r = v;
        for (int k = 0; k < 4; k++) begin
            if (int'(r) >= m) r = r - BYTE_W'(m);
        end
        return r;
    endfunction

endpackage

// File: rtl/awc_wrap_ctr.sv
`timescale 1ns/1ps
module awc_wrap_ctr #(
    parameter int MAXV    = 64,
    parameter int W       = $clog2(MAXV),
    parameter int RST_END = MAXV - 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] ld_start,
    input  logic [W-1:0] ld_end,
    input  logic         step,
    output logic [W-1:0] cur_eff,
    output logic         wrap_eff
);
    logic [W-1:0] cur_q, start_q, end_q;
    logic [W-1:0] base, lim, st;

    // A same-cycle load overrides the stored window and position.
    always_comb begin
        st       = load ? ld_start : start_q;
        lim      = load ? ld_end   : end_q;
        base     = load ? ld_start : cur_q;
        wrap_eff = (base >= lim);
        cur_eff  = base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            start_q <= '0;
            end_q   <= W'(RST_END);
        end else begin
            if (load) begin
                start_q <= ld_start;
                end_q   <= ld_end;
            end
            if (step) cur_q <= wrap_eff ? st : base + 1'b1;
            else      cur_q <= base;
        end
    end

    // R1
    cur_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cur_q} < (W+1)'(MAXV)));

    // R5
    load_sets_start_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !step) |=> (cur_q == $past(ld_start)));

    // R10
    wrap_to_start_chk: assert property (@(posedge clk) disable iff (rst)
        (step && (base >= lim)) |=> (cur_q == $past(st)));

endmodule

// File: rtl/awc_step_ctrl.sv
`timescale 1ns/1ps
module awc_step_ctrl
    import awc_pkg::*;
#(
    parameter int CMD_W    = 8,
    parameter int VERT_BIT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_load,
    input  logic [CMD_W-1:0] mode_in,
    input  logic             data_valid,
    input  logic             col_wrap,
    input  logic             row_wrap,
    output logic             col_step,
    output logic             row_step
);
    trav_e mode_q, mode_eff;

    always_comb begin
        mode_eff = mode_load ? trav_e'(mode_in[VERT_BIT]) : mode_q;
        if (mode_eff == TRAV_VERT) begin
            row_step = data_valid;
            col_step = data_valid && row_wrap;
        end else begin
            col_step = data_valid;
            row_step = data_valid && col_wrap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            mode_q <= TRAV_HORIZ;
        else if (mode_load) mode_q <= trav_e'(mode_in[VERT_BIT]);
    end

    // R2
    horiz_row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_valid && !mode_load && mode_q == TRAV_HORIZ && !col_wrap) |-> !row_step);

    // R4
    vert_col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_valid && !mode_load && mode_q == TRAV_VERT && !row_wrap) |-> !col_step);

    // R1
    idle_no_step_chk: assert property (@(posedge clk) disable iff (rst)
        !data_valid |-> (!col_step && !row_step));

endmodule

// File: rtl/awc_out_stage.sv
`timescale 1ns/1ps
module awc_out_stage
    import awc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 data_valid,
    input  logic [BYTE_W-1:0]    data_in,
    input  logic [COL_W-1:0]     col,
    input  logic [ROW_W-1:0]     row,
    input  logic                 redraw_clr,
    output logic                 mem_we,
    output logic [FB_ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0]    mem_data,
    output logic                 redraw
);
    wr_beat_t beat_d, beat_q;
    logic     redraw_q;

    always_comb begin
        beat_d.we   = data_valid;
        beat_d.addr = FB_ADDR_W'(row) * FB_ADDR_W'(FB_COLS) + FB_ADDR_W'(col);
        beat_d.data = data_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q   <= '0;
            redraw_q <= 1'b0;
        end else begin
            beat_q <= beat_d;
            if (data_valid)      redraw_q <= 1'b1;
            else if (redraw_clr) redraw_q <= 1'b0;
        end
    end

    assign mem_we   = beat_q.we;
    assign mem_addr = beat_q.addr;
    assign mem_data = beat_q.data;
    assign redraw   = redraw_q;

    // R11
    we_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> mem_we);

    // R1
    addr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ({1'b0, mem_addr} < (FB_ADDR_W+1)'(FB_BYTES)));

    // R8
    redraw_set_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> redraw);

    // R8
    redraw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!data_valid && !redraw_clr) |=> (redraw == $past(redraw)));

endmodule

// File: rtl/awc_addr_gen.sv
`timescale 1ns/1ps
module awc_addr_gen
    import awc_pkg::*;
#(
    parameter int CMD_W    = 8,
    parameter int VERT_BIT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 col_win_load,
    input  logic [CMD_W-1:0]     col_start_in,
    input  logic [CMD_W-1:0]     col_end_in,
    input  logic                 row_win_load,
    input  logic [CMD_W-1:0]     row_start_in,
    input  logic [CMD_W-1:0]     row_end_in,
    input  logic                 mode_load,
    input  logic [CMD_W-1:0]     mode_in,
    input  logic                 data_valid,
    input  logic [BYTE_W-1:0]    data_in,
    input  logic                 redraw_clr,
    output logic                 mem_we,
    output logic [FB_ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0]    mem_data,
    output logic                 redraw
);
    logic [COL_W-1:0] col_ld_s, col_ld_e, col_cur;
    logic [ROW_W-1:0] row_ld_s, row_ld_e, row_cur;
    logic             col_wrap, row_wrap, col_step, row_step;

    // Window values are reduced into range before they reach the counters.
    always_comb begin
        col_ld_s = COL_W'(mod_reduce(BYTE_W'(col_start_in), FB_COLS));
        col_ld_e = COL_W'(mod_reduce(BYTE_W'(col_end_in),   FB_COLS));
        row_ld_s = ROW_W'(mod_reduce(BYTE_W'(row_start_in), FB_ROWS));
        row_ld_e = ROW_W'(mod_reduce(BYTE_W'(row_end_in),   FB_ROWS));
    end

    awc_wrap_ctr #(.MAXV(FB_COLS), .W(COL_W), .RST_END(FB_COLS-1)) col_ctr_i (
        .clk(clk), .rst(rst), .load(col_win_load),
        .ld_start(col_ld_s), .ld_end(col_ld_e), .step(col_step),
        .cur_eff(col_cur), .wrap_eff(col_wrap));

    awc_wrap_ctr #(.MAXV(FB_ROWS), .W(ROW_W), .RST_END(FB_ROWS-1)) row_ctr_i (
        .clk(clk), .rst(rst), .load(row_win_load),
        .ld_start(row_ld_s), .ld_end(row_ld_e), .step(row_step),
        .cur_eff(row_cur), .wrap_eff(row_wrap));

    awc_step_ctrl #(.CMD_W(CMD_W), .VERT_BIT(VERT_BIT)) step_i (
        .clk(clk), .rst(rst), .mode_load(mode_load), .mode_in(mode_in),
        .data_valid(data_valid), .col_wrap(col_wrap), .row_wrap(row_wrap),
        .col_step(col_step), .row_step(row_step));

    awc_out_stage out_i (
        .clk(clk), .rst(rst), .data_valid(data_valid), .data_in(data_in),
        .col(col_cur), .row(row_cur), .redraw_clr(redraw_clr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .redraw(redraw));

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!mem_we && !redraw));

endmodule

// File: tb/awc_addr_gen_tb.sv
`timescale 1ns/1ps
module awc_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        col_win_load, row_win_load, mode_load, data_valid, redraw_clr;
    logic [7:0]  col_start_in, col_end_in, row_start_in, row_end_in, mode_in, data_in;
    logic        mem_we, redraw;
    logic [12:0] mem_addr;
    logic [7:0]  mem_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    awc_addr_gen dut_i (
        .clk(clk), .rst(rst),
        .col_win_load(col_win_load), .col_start_in(col_start_in), .col_end_in(col_end_in),
        .row_win_load(row_win_load), .row_start_in(row_start_in), .row_end_in(row_end_in),
        .mode_load(mode_load), .mode_in(mode_in),
        .data_valid(data_valid), .data_in(data_in), .redraw_clr(redraw_clr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .redraw(redraw));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        col_win_load = 0; row_win_load = 0; mode_load = 0;
        data_valid = 0; redraw_clr = 0;
    endtask

    task automatic load_col(input int s, input int e);
        @(negedge clk);
        col_win_load = 1; col_start_in = 8'(s); col_end_in = 8'(e);
        @(negedge clk);
        col_win_load = 0;
    endtask

    task automatic load_row(input int s, input int e);
        @(negedge clk);
        row_win_load = 1; row_start_in = 8'(s); row_end_in = 8'(e);
        @(negedge clk);
        row_win_load = 0;
    endtask

    task automatic load_mode(input int m);
        @(negedge clk);
        mode_load = 1; mode_in = 8'(m);
        @(negedge clk);
        mode_load = 0;
    endtask

    // One strobe; outputs checked one edge later (R11).
    task automatic write_chk(input int d, input int exp_addr, input string req);
        @(negedge clk);
        data_valid = 1; data_in = 8'(d);
        @(negedge clk);
        data_valid = 0;
        check(mem_we == 1'b1, {req, " R11 we"}, int'(mem_we), 1);
        check(int'(mem_addr) == exp_addr, {req, " addr"}, int'(mem_addr), exp_addr);
        check(int'(mem_data) == d, {req, " R1 data"}, int'(mem_data), d);
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs();
        col_start_in = 0; col_end_in = 0; row_start_in = 0; row_end_in = 0;
        mode_in = 0; data_in = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check(mem_we == 1'b0, "R7 we", int'(mem_we), 0);
        check(redraw == 1'b0, "R7 redraw", int'(redraw), 0);
        write_chk(8'h11, 0, "R7 first");
        write_chk(8'h22, 1, "R7 second");
        @(negedge clk);
        check(mem_we == 1'b0, "R1 single beat", int'(mem_we), 0);
    endtask

    task automatic t_horizontal();
        load_col(2, 4);
        load_row(1, 2);
        write_chk(8'hA0, 66,  "R2 h0");
        write_chk(8'hA1, 67,  "R2 h1");
        write_chk(8'hA2, 68,  "R2 h2");
        write_chk(8'hA3, 130, "R2 row step");
        write_chk(8'hA4, 131, "R2 h4");
        write_chk(8'hA5, 132, "R2 h5");
        write_chk(8'hA6, 66,  "R3 row wrap");
    endtask

    task automatic t_vertical();
        load_mode(8'h04);
        load_col(10, 11);
        load_row(5, 6);
        write_chk(8'h01, 330, "R4 v0");
        write_chk(8'h02, 394, "R4 v1");
        write_chk(8'h03, 331, "R4 col step");
        write_chk(8'h04, 395, "R4 v3");
        write_chk(8'h05, 330, "R4 col wrap");
    endtask

    task automatic t_modulo();
        load_mode(8'hFB);    // bit 2 clear, all others set: horizontal (R4)
        load_col(70, 200);   // 6 .. 8 (R5)
        load_row(250, 85);   // 10 .. 5 (R6), end below start (R10)
        write_chk(8'h31, 646, "R5 R6 mod start");
        write_chk(8'h32, 647, "R4 other bits ignored");
        write_chk(8'h33, 648, "R5 mod end");
        write_chk(8'h34, 646, "R10 row inverted wrap");
    endtask

    task automatic t_inverted_col();
        load_col(5, 3);
        load_row(0, 1);
        write_chk(8'h41, 5,  "R10 c0");
        write_chk(8'h42, 69, "R10 col inverted wrap");
        write_chk(8'h43, 5,  "R10 row back");
    endtask

    task automatic t_same_cycle();
        load_row(3, 3);
        load_col(0, 63);
        write_chk(8'h50, 192, "R9 pre");
        @(negedge clk);
        col_win_load = 1; col_start_in = 20; col_end_in = 21;
        data_valid = 1; data_in = 8'h51;
        @(negedge clk);
        col_win_load = 0; data_valid = 0;
        check(int'(mem_addr) == 212, "R9 new start", int'(mem_addr), 212);
        write_chk(8'h52, 213, "R9 continue");
        // mode load with write: new mode used (vertical), row window 3..3
        load_col(7, 9);
        @(negedge clk);
        mode_load = 1; mode_in = 8'h04; data_valid = 1; data_in = 8'h53;
        @(negedge clk);
        mode_load = 0; data_valid = 0;
        check(int'(mem_addr) == 199, "R9 mode same cycle", int'(mem_addr), 199);
        write_chk(8'h54, 200, "R9 vertical step");
        load_mode(0);
    endtask

    task automatic t_redraw();
        @(negedge clk);
        redraw_clr = 1;
        @(negedge clk);
        redraw_clr = 0;
        check(redraw == 1'b0, "R8 clear", int'(redraw), 0);
        repeat (3) @(negedge clk);
        check(redraw == 1'b0, "R8 stays clear", int'(redraw), 0);
        load_col(63, 63);
        load_row(79, 79);
        check(redraw == 1'b0, "R8 load no set", int'(redraw), 0);
        write_chk(8'hFF, 5119, "R1 top address");
        check(redraw == 1'b1, "R8 set", int'(redraw), 1);
        repeat (3) @(negedge clk);
        check(redraw == 1'b1, "R8 holds", int'(redraw), 1);
        @(negedge clk);
        redraw_clr = 1;
        @(negedge clk);
        redraw_clr = 1; data_valid = 1; data_in = 8'h5A;
        @(negedge clk);
        redraw_clr = 0; data_valid = 0;
        check(redraw == 1'b1, "R8 set beats clear", int'(redraw), 1);
        check(int'(mem_addr) == 5119, "R1 corner wrap", int'(mem_addr), 5119);
    endtask

    initial begin
        t_reset();
        t_horizontal();
        t_vertical();
        t_modulo();
        t_inverted_col();
        t_same_cycle();
        t_redraw();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule